// File: doc/BRIEF.md
# Three-Wire Register Write Port

This block receives configuration words over a write-only, three-line serial link (data, bit clock and a load strobe) and turns them into parallel register contents for the rest of an audio datapath. Words are 16 bits long and arrive most significant bit first. When the load strobe rises, the two lowest bits of the word choose one of three destinations (left volume, right volume or the control word), and the upper 14 bits are stored there.

All three serial lines are treated as asynchronous. They are brought into the system clock domain through synchronizer chains, and their edges are found there. The serial bit clock must therefore run well below the system clock. Each volume update gives a one-cycle strobe so that a downstream ramp circuit can start. The control fields that have a matching board pin are presented ORed with that pin, so a board that never drives the serial link can still set mute, input format and interpolation ratio.

Top module: `cw_regport`

## Requirements
- R1: On each rising edge of `ser_clk`, the value of `ser_dat` is shifted into a 16-bit word, first bit most significant. On a rising edge of `ser_lat`, word bits [1:0] choose the destination and bits [15:2] are stored: code 00 writes `vol_left`, code 10 writes `vol_right`, code 01 writes the control fields.
- R2: A word whose bits [1:0] are 11 changes no register and raises no strobe.
- R3: Each volume write raises only that register's strobe (`vol_left_wr` or `vol_right_wr`) for exactly one cycle. The new value appears in that same cycle. A control write raises no strobe. A volume output changes only together with its strobe.
- R4: The control fields are taken from these word positions: bit 11 gives `interp_2x`, bit 10 gives `interp_4x`, bits [9:8] give `rj_len` (00 = 24, 01 = 20, 10 = 16 bits), bit 7 gives `soft_reset`, bit 6 gives `mute`, bits [5:4] give `serial_mode`, and bits [3:2] give `deemph_sel`.
- R5: Word bits [15:12] of a control write are discarded. A control write with those bits set gives the same field outputs as one with them clear.
- R6: While `rst_n` is low at a rising `clk` edge (synchronous, active low), both volumes return to all ones (0x3FFF) and every control field returns to zero.
- R7: `mute` is the stored bit ORed with `pin_mute`. `serial_mode` is the stored field ORed bitwise with `pin_mode`. `interp_2x` and `interp_4x` are ORed with `pin_int2` and `pin_int4`. The other fields ignore the pins.
- R8: If more or fewer than 16 bit clocks arrive before the load strobe, the last 16 bits shifted in are written.
- R9: A rising edge of `ser_lat` that is set up before a `clk` edge shows up at the outputs on the third rising `clk` edge. It does not show up on the second.
- R10: Only a rising edge of `ser_lat` writes. Bits shifted in while the strobe is held high change nothing until the strobe falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_dat | input | 1 | Serial data, asynchronous |
| ser_lat | input | 1 | Serial load strobe, asynchronous |
| pin_mute | input | 1 | Board mute pin |
| pin_mode | input | 2 | Board input-format pins |
| pin_int4 | input | 1 | Board 4x interpolation pin |
| pin_int2 | input | 1 | Board 2x interpolation pin |
| vol_left | output | 14 | Left volume word |
| vol_right | output | 14 | Right volume word |
| vol_left_wr | output | 1 | One-cycle left volume write strobe |
| vol_right_wr | output | 1 | One-cycle right volume write strobe |
| interp_2x | output | 1 | 2x interpolation select |
| interp_4x | output | 1 | 4x interpolation select |
| rj_len | output | 2 | Right-justified word length code |
| soft_reset | output | 1 | Soft reset field |
| mute | output | 1 | Mute request |
| serial_mode | output | 2 | Input format select |
| deemph_sel | output | 2 | De-emphasis curve select |

## Verification
A set of words walks every address code. It uses patterns of all ones, all zeros and alternating bits, so a wrong decode, a swapped left/right or an off-by-one payload slice gives a distinct wrong value. Control words with and without the reserved bits set separate field mapping from reserved-bit handling. Frames of 20 and 8 bits show whether the port keeps the most recent 16 bits. A latch held high while new bits arrive, and a cycle-exact probe around the latch edge, test that writes are edge-driven and arrive with the stated synchronizer latency. Pin patterns over a zero control word separate ORed fields from fields the pins must not reach.

// File: rtl/cw_pkg.sv
// Shared types for the three-wire register write port.
// Assumes the control payload is at least 10 bits wide.
package cw_pkg;

    typedef enum logic [1:0] {
        ADR_VOL_L = 2'b00,
        ADR_CTRL  = 2'b01,
        ADR_VOL_R = 2'b10,
        ADR_NONE  = 2'b11
    } addr_e;

    // Stored control fields, highest word position first (word bits 11..2).
    typedef struct packed {
        logic       int2;
        logic       int4;
        logic [1:0] rj_len;
        logic       soft_rst;
        logic       mute;
        logic [1:0] mode;
        logic [1:0] deemph;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/cw_sync.sv
// Multi-stage synchronizer for asynchronous level inputs.
// Assumes each input is held long enough for the system clock to see it.
// RST_VAL sets the reset level of every stage, bit by bit.
module cw_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [STAGES-1:0][W-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Move the value one stage further along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain[g] <= RST_VAL;
                end else if (g == 0) begin
                    chain[g] <= d_async;
                end else begin
                    chain[g] <= chain[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/cw_shifter.sv
// Finds edges on the synchronized bit clock and load strobe, and shifts data
// into the word register MSB first. Assumes the inputs are already in the clk domain.
module cw_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              sdat_s,
    input  logic              slat_s,
    output logic [WORD_W-1:0] word,
    output logic              lat_evt
);

    logic sclk_q;
    logic slat_q;
    logic sclk_rise;

    assign sclk_rise = sclk_s & ~sclk_q;
    assign lat_evt   = slat_s & ~slat_q;

    // Keep the previous levels so edges can be detected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            slat_q <= 1'b1;
        end else begin
            sclk_q <= sclk_s;
            slat_q <= slat_s;
        end
    end

    // Shift one data bit on every bit-clock rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
        end else if (sclk_rise) begin
            word <= {word[WORD_W-2:0], sdat_s};
        end
    end

    // R10: a load event is a single-cycle edge, never a level.
    a_r10_evt_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        lat_evt |=> !lat_evt);

endmodule

// File: rtl/cw_regfile.sv
// Decodes the address bits on a load event and updates the volume and control
// registers. Assumes lat_evt is a one-cycle pulse aligned with a stable word.
module cw_regfile
    import cw_pkg::*;
#(
    parameter int              WORD_W    = 16,
    parameter int              ADDR_W    = 2,
    parameter int              PAY_W     = WORD_W - ADDR_W,
    parameter logic [PAY_W-1:0] VOL_RESET = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word,
    input  logic              lat_evt,
    output logic [PAY_W-1:0]  vol_l,
    output logic [PAY_W-1:0]  vol_r,
    output logic              vol_l_wr,
    output logic              vol_r_wr,
    output ctrl_t             ctrl_q
);

    logic [PAY_W-1:0] payload;
    addr_e            addr;

    assign payload = word[WORD_W-1:ADDR_W];
    assign addr    = addr_e'(word[ADDR_W-1:0]);

    // Write the chosen register and raise the matching strobe for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vol_l    <= VOL_RESET;
            vol_r    <= VOL_RESET;
            vol_l_wr <= 1'b0;
            vol_r_wr <= 1'b0;
            ctrl_q   <= '0;
        end else begin
            vol_l_wr <= 1'b0;
            vol_r_wr <= 1'b0;
            if (lat_evt) begin
                case (addr)
                    ADR_VOL_L: begin
                        vol_l    <= payload;
                        vol_l_wr <= 1'b1;
                    end
                    ADR_VOL_R: begin
                        vol_r    <= payload;
                        vol_r_wr <= 1'b1;
                    end
                    ADR_CTRL:  ctrl_q <= ctrl_t'(payload[CTRL_W-1:0]);
                    default:   ;
                endcase
            end
        end
    end

    // R3: strobes last exactly one cycle.
    a_r3_left_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        vol_l_wr |=> !vol_l_wr);
    a_r3_right_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        vol_r_wr |=> !vol_r_wr);
    // R3: a volume changes only together with its strobe.
    a_r3_left_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vol_l) |-> vol_l_wr);
    a_r3_right_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vol_r) |-> vol_r_wr);
    // R3: a control write raises no strobe.
    a_r3_ctrl_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_evt && word[ADDR_W-1:0] == 2'b01) |=> (!vol_l_wr && !vol_r_wr));
    // R2: code 11 leaves everything untouched.
    a_r2_code3_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_evt && word[ADDR_W-1:0] == 2'b11)
            |=> (!vol_l_wr && !vol_r_wr && $stable(ctrl_q)));

endmodule

// File: rtl/cw_regport.sv
// Top of the three-wire register write port. Synchronizes the serial lines,
// assembles words, writes registers, and ORs the pin-backed control fields.
// Assumes the serial bit clock has high and low phases of several clk cycles each.
module cw_regport
    import cw_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int ADDR_W      = 2,
    parameter int SYNC_STAGES = 2,
    localparam int PAY_W      = WORD_W - ADDR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk,
    input  logic             ser_dat,
    input  logic             ser_lat,
    input  logic             pin_mute,
    input  logic [1:0]       pin_mode,
    input  logic             pin_int4,
    input  logic             pin_int2,
    output logic [PAY_W-1:0] vol_left,
    output logic [PAY_W-1:0] vol_right,
    output logic             vol_left_wr,
    output logic             vol_right_wr,
    output logic             interp_2x,
    output logic             interp_4x,
    output logic [1:0]       rj_len,
    output logic             soft_reset,
    output logic             mute,
    output logic [1:0]       serial_mode,
    output logic [1:0]       deemph_sel
);

    logic [1:0]        cd_s;
    logic              lat_s;
    logic [WORD_W-1:0] word;
    logic              lat_evt;
    ctrl_t             ctrl_q;

    cw_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_sync_cd (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({ser_clk, ser_dat}),
        .q_sync  (cd_s)
    );

    // The strobe chain resets high so a line held high at reset makes no write.
    cw_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_lat (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (ser_lat),
        .q_sync  (lat_s)
    );

    cw_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (cd_s[1]),
        .sdat_s  (cd_s[0]),
        .slat_s  (lat_s),
        .word    (word),
        .lat_evt (lat_evt)
    );

    cw_regfile #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .PAY_W(PAY_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .word     (word),
        .lat_evt  (lat_evt),
        .vol_l    (vol_left),
        .vol_r    (vol_right),
        .vol_l_wr (vol_left_wr),
        .vol_r_wr (vol_right_wr),
        .ctrl_q   (ctrl_q)
    );

    // Merge the stored fields with their board pins where a pin exists.
    always_comb begin
        interp_2x   = ctrl_q.int2 | pin_int2;
        interp_4x   = ctrl_q.int4 | pin_int4;
        rj_len      = ctrl_q.rj_len;
        soft_reset  = ctrl_q.soft_rst;
        mute        = ctrl_q.mute | pin_mute;
        serial_mode = ctrl_q.mode | pin_mode;
        deemph_sel  = ctrl_q.deemph;
    end

    // R6: while reset is applied, the volumes read back the all-ones default.
    a_r6_vol_default: assert property (@(posedge clk)
        $fell(rst_n) |=> (vol_left == '1 && vol_right == '1));

endmodule

// File: tb/cw_regport_tb_top.sv
module cw_regport_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0, ser_dat = 1'b0, ser_lat = 1'b0;
    logic        pin_mute = 1'b0, pin_int4 = 1'b0, pin_int2 = 1'b0;
    logic [1:0]  pin_mode = 2'b00;
    logic [13:0] vol_left, vol_right;
    logic        vol_left_wr, vol_right_wr;
    logic        interp_2x, interp_4x, soft_reset, mute;
    logic [1:0]  rj_len, serial_mode, deemph_sel;

    int errors = 0;
    int checks = 0;
    int n_l = 0;
    int n_r = 0;

    logic [13:0] m_l = 14'h3FFF;
    logic [13:0] m_r = 14'h3FFF;
    logic [9:0]  m_c = 10'h000;

    always #4 clk = ~clk;

    cw_regport dut_i (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_lat(ser_lat),
        .pin_mute(pin_mute), .pin_mode(pin_mode), .pin_int4(pin_int4), .pin_int2(pin_int2),
        .vol_left(vol_left), .vol_right(vol_right), .vol_left_wr(vol_left_wr),
        .vol_right_wr(vol_right_wr), .interp_2x(interp_2x), .interp_4x(interp_4x),
        .rj_len(rj_len), .soft_reset(soft_reset), .mute(mute), .serial_mode(serial_mode),
        .deemph_sel(deemph_sel)
    );

    // Count strobe pulses away from the active edge.
    always @(negedge clk) begin
        if (vol_left_wr)  n_l++;
        if (vol_right_wr) n_r++;
    end

    localparam logic [15:0] VEC [8] = '{
        16'hABC0, 16'h1232, 16'h0E01, 16'hFFFF,
        16'h0000, 16'hFFFE, 16'hF155, 16'h02A9
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [9:0] ctrl_out();
        return {interp_2x, interp_4x, rj_len, soft_reset, mute, serial_mode, deemph_sel};
    endfunction

    task automatic shift_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk); ser_clk = 1'b0; ser_dat = v[i];
            repeat (4) @(negedge clk);
            ser_clk = 1'b1;
            repeat (4) @(negedge clk);
        end
        ser_clk = 1'b0;
    endtask

    task automatic latch_pulse();
        @(negedge clk); ser_lat = 1'b1;
        repeat (6) @(negedge clk);
        ser_lat = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    // Bench model of a write, written from R1, R2 and R4.
    task automatic model_write(input logic [15:0] w);
        case (w[1:0])
            2'b00: m_l = w[15:2];
            2'b10: m_r = w[15:2];
            2'b01: m_c = w[11:2];
            default: ;
        endcase
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        m_l = 14'h3FFF; m_r = 14'h3FFF; m_c = '0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        // R6: defaults after reset.
        chk("R6 vol_left", vol_left, 14'h3FFF);
        chk("R6 vol_right", vol_right, 14'h3FFF);
        chk("R6 ctrl", ctrl_out(), 10'h000);

        // Main vector walk: R1, R2, R3, R4, R5.
        for (int k = 0; k < 8; k++) begin
            int l0, r0;
            l0 = n_l; r0 = n_r;
            shift_bits(VEC[k], 16);
            latch_pulse();
            model_write(VEC[k]);
            chk("R1 vol_left", vol_left, m_l);
            chk("R1 vol_right", vol_right, m_r);
            chk("R4 R5 ctrl fields", ctrl_out(), m_c);
            chk("R3 R2 left strobes", n_l - l0, (VEC[k][1:0] == 2'b00) ? 1 : 0);
            chk("R3 R2 right strobes", n_r - r0, (VEC[k][1:0] == 2'b10) ? 1 : 0);
        end

        // R5: reserved bits set, same fields as without.
        shift_bits(16'hF0A5, 16); latch_pulse();
        chk("R5 reserved dropped", ctrl_out(), 10'h029);

        // R7: pins over a zero control word.
        shift_bits(16'h0001, 16); latch_pulse();
        pin_mute = 1'b1; pin_mode = 2'b01; pin_int2 = 1'b1;
        @(negedge clk);
        chk("R7 pins ored", ctrl_out(), 10'b1000010100);
        pin_mute = 1'b0; pin_mode = 2'b10; pin_int2 = 1'b0; pin_int4 = 1'b1;
        @(negedge clk);
        chk("R7 pins ored b", ctrl_out(), 10'b0100001000);
        pin_mode = 2'b00; pin_int4 = 1'b0;
        shift_bits(16'h0559, 16); latch_pulse();
        pin_mute = 1'b1; pin_mode = 2'b11;
        @(negedge clk);
        chk("R7 or with stored", ctrl_out(), 10'b0101011110);
        pin_mute = 1'b0; pin_mode = 2'b00;

        // R8: long then short frame.
        shift_bits(32'h000A4002, 20); latch_pulse();
        chk("R8 long frame", vol_right, 14'h1000);
        shift_bits(32'h00000000, 8); latch_pulse();
        chk("R8 short frame", vol_left, 14'h0080);

        // R9: latency of the load edge.
        shift_bits(16'h5554, 16);
        @(negedge clk); ser_lat = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 not yet", vol_left, 14'h0080);
        @(negedge clk);
        chk("R9 third edge", vol_left, 14'h1555);
        chk("R9 strobe", vol_left_wr, 1'b1);

        // R10: strobe held high while new bits arrive.
        shift_bits(16'h0002, 16);
        repeat (6) @(negedge clk);
        chk("R10 held high right", vol_right, 14'h1000);
        ser_lat = 1'b0;
        repeat (6) @(negedge clk);
        chk("R10 after fall", vol_right, 14'h1000);
        latch_pulse();
        chk("R10 next rise writes", vol_right, 14'h0000);

        // R6: reset in mid-run restores defaults.
        do_reset();
        chk("R6 reset vol_left", vol_left, 14'h3FFF);
        chk("R6 reset vol_right", vol_right, 14'h3FFF);
        chk("R6 reset ctrl", ctrl_out(), 10'h000);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule